// File: doc/BRIEF.md
# Selectable-Order Single-Bit Noise Shaper

This block is the final digital stage of an oversampling audio converter. On each enabled cycle of the oversampled clock it takes one signed PCM sample and turns it into a single output bit. Averaged over time, the bit density follows the input, and the quantization error is pushed out of the audio band. The loop is a chain of integrators. The quantized output is fed back, as plus or minus full scale, into the input of every integrator.

A run-time select bit picks a third-order or a fifth-order loop. Both orders use the same first three integrators. The fifth-order mode only adds two more stages, and those two are held at zero while the third-order mode is active. Each input word may be 16, 18, 20 or 24 bits wide. It arrives sign-extended in a 24-bit bus and is moved to the top of the datapath before use. The upstream interpolator drives the enable at 128 or 256 times the sample rate. Every loop gain is a right shift, and every integrator clamps at a fixed bound instead of wrapping.

Top module: `cifb_shaper`

## Requirements
- R1: While `rst` is high at a clock edge, all five integrators are cleared and third-order mode is selected. Right after reset, `bit_out` is 1.
- R2: `fmt` selects the input width w: 0 → 16, 1 → 18, 2 → 20, 3 → 24 bits. The low w bits of `din` are read as a two's-complement value and shifted left by 24−w. Bits of `din` above bit w−1 have no effect.
- R3: In third-order mode (mode bit 0), integrators 4 and 5 stay at zero and the quantizer reads integrator 3.
- R4: In fifth-order mode (mode bit 1), the quantizer reads integrator 5.
- R5: On an enabled edge, every integrator k is updated from the old state as acc_k ← acc_k + ((in_k − v) >>> s_k), with right shifts s = 1, 2, 2, 3, 3. Here in_1 is the aligned input, in_k is the old acc_(k−1) for k > 1, and v is +2^(DW−1) when `bit_out` is 1 and −2^(DW−1) when it is 0.
- R6: Every integrator update is clamped to the range ±(2^(DW+GUARD−1) − 1).
- R7: `bit_out` is 1 when the integrator read by the quantizer is non-negative, and 0 otherwise.
- R8: On an edge where `order5` differs from the current mode, all integrators are cleared and the mode takes the value of `order5`, whatever the value of `en`.
- R9: On an edge with `en` low, no reset and no order change, the integrator state and `bit_out` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Oversampled-rate update enable |
| fmt | input | 2 | Input word width code |
| order5 | input | 1 | 1 selects fifth order, 0 selects third order |
| din | input | DW | Sign-extended input sample |
| bit_out | output | 1 | One-bit modulator output |

## Verification
The bench builds the block with DW = 24 and GUARD = 2. This lowers the integrator clamp to about four times full scale, so full-scale and overloaded inputs drive the loop into the clamp within a few hundred cycles. A behavioural model made of wide integers is stepped next to the design, and the output bit is compared on every cycle. The stimulus covers:
- both orders, including switches between them in the middle of a run;
- all four input widths, with noise placed in the unused upper bits;
- gaps in the enable;
- a reset in the middle of a run.

// File: rtl/cifb_pkg.sv
package cifb_pkg;
    localparam int N_ST      = 5;
    localparam int LOW_ORDER = 3;

    typedef enum logic [1:0] {
        FMT_W16 = 2'd0,
        FMT_W18 = 2'd1,
        FMT_W20 = 2'd2,
        FMT_W24 = 2'd3
    } fmt_e;

    function automatic int fmt_bits(input fmt_e f);
        case (f)
            FMT_W16: return 16;
            FMT_W18: return 18;
            FMT_W20: return 20;
            default: return 24;
        endcase
    endfunction
endpackage

// File: rtl/cifb_align.sv
module cifb_align #(
    parameter int DW = 24
) (
    input  logic [DW-1:0]        din,
    input  cifb_pkg::fmt_e       fmt,
    output logic signed [DW-1:0] u
);
    // R2: left-align the narrow word; bits above its width shift out
    always_comb begin
        u = $signed(din << (DW - cifb_pkg::fmt_bits(fmt)));
    end
endmodule

// File: rtl/cifb_stage.sv
module cifb_stage #(
    parameter int W     = 28,
    parameter int SHIFT = 1
) (
    input  logic signed [W-1:0] acc,
    input  logic signed [W-1:0] prev,
    input  logic signed [W-1:0] fb,
    output logic signed [W-1:0] nxt
);
    localparam logic signed [W+1:0] LIM_P = {3'b000, {(W-1){1'b1}}};
    localparam logic signed [W+1:0] LIM_N = -LIM_P;

    logic signed [W:0]   diff;
    logic signed [W:0]   step;
    logic signed [W+1:0] sum;

    always_comb begin
        diff = $signed({prev[W-1], prev}) - $signed({fb[W-1], fb});
        step = diff >>> SHIFT;
        sum  = $signed({{2{acc[W-1]}}, acc}) + $signed({step[W], step});
        if (sum > LIM_P) begin
            nxt = LIM_P[W-1:0];
        end else if (sum < LIM_N) begin
            nxt = LIM_N[W-1:0];
        end else begin
            nxt = sum[W-1:0];
        end
    end
endmodule

// File: rtl/cifb_shaper.sv
module cifb_shaper #(
    parameter int          DW           = 24,
    parameter int          GUARD        = 4,
    parameter logic [19:0] STAGE_SHIFTS = {4'd3, 4'd3, 4'd2, 4'd2, 4'd1}
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [1:0]    fmt,
    input  logic          order5,
    input  logic [DW-1:0] din,
    output logic          bit_out
);
    import cifb_pkg::*;

    localparam int W = DW + GUARD;
    localparam logic signed [W-1:0] FB_POS = W'(64'd1 << (DW - 1));
    localparam logic signed [W-1:0] FB_NEG = -FB_POS;
    localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    typedef struct packed {
        logic                    mode5;
        logic [N_ST-1:0][W-1:0]  acc;
    } state_t;

    state_t st_d, st_q;

    logic signed [DW-1:0] u;
    logic signed [W-1:0]  fb;
    logic signed [W-1:0]  sel;
    logic signed [W-1:0]  prev [N_ST];
    logic signed [W-1:0]  nxt  [N_ST];

    cifb_align #(.DW(DW)) i_align (
        .din (din),
        .fmt (fmt_e'(fmt)),
        .u   (u)
    );

    // R3 R4 R7: quantizer tap depends on the mode
    assign sel     = st_q.mode5 ? $signed(st_q.acc[N_ST-1]) : $signed(st_q.acc[LOW_ORDER-1]);
    assign bit_out = ~sel[W-1];
    assign fb      = bit_out ? FB_POS : FB_NEG;

    for (genvar k = 0; k < N_ST; k++) begin : g_stage
        if (k == 0) begin : g_first
            assign prev[k] = {{GUARD{u[DW-1]}}, u};
        end else begin : g_rest
            assign prev[k] = $signed(st_q.acc[k-1]);
        end
        cifb_stage #(
            .W     (W),
            .SHIFT (int'(STAGE_SHIFTS[4*k +: 4]))
        ) i_stage (
            .acc  ($signed(st_q.acc[k])),
            .prev (prev[k]),
            .fb   (fb),
            .nxt  (nxt[k])
        );
    end

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.mode5 = 1'b0;
            st_d.acc   = '0;
        end else if (order5 != st_q.mode5) begin
            st_d.mode5 = order5;
            st_d.acc   = '0;
        end else if (en) begin
            for (int k = 0; k < N_ST; k++) begin
                st_d.acc[k] = (k >= LOW_ORDER && !st_q.mode5) ? '0 : nxt[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (st_q.acc == '0 && !st_q.mode5 && bit_out));

    // R3
    third_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !st_q.mode5 |-> (st_q.acc[3] == '0 && st_q.acc[4] == '0));

    // R8
    order_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (order5 != st_q.mode5) |=> (st_q.acc == '0 && st_q.mode5 == $past(order5)));

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && order5 == st_q.mode5) |=> ($stable(st_q) && $stable(bit_out)));

    for (genvar k = 0; k < N_ST; k++) begin : g_bound
        // R6
        no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> ($signed(st_q.acc[k]) != MOST_NEG));
    end
endmodule

// File: tb/test_cifb_shaper.sv
module test_cifb_shaper;
    localparam int DW    = 24;
    localparam int GUARD = 2;
    localparam int W     = DW + GUARD;
    localparam longint FS  = longint'(1) << (DW - 1);
    localparam longint LIM = (longint'(1) << (W - 1)) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [1:0]    fmt = 2'd3;
    logic          order5 = 1'b0;
    logic [DW-1:0] din = '0;
    logic          bit_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    longint m [5];
    bit     mmode;
    int     sh [5] = '{1, 2, 2, 3, 3};

    cifb_shaper #(.DW(DW), .GUARD(GUARD)) i_cifb_shaper (
        .clk(clk), .rst(rst), .en(en), .fmt(fmt),
        .order5(order5), .din(din), .bit_out(bit_out)
    );

    always #10 clk = ~clk;

    // R2: width codes 0..3 -> 16/18/20/24 bits
    function automatic longint align(input logic [DW-1:0] d, input logic [1:0] f);
        int     w;
        longint val;
        w   = (f == 2'd0) ? 16 : (f == 2'd1) ? 18 : (f == 2'd2) ? 20 : 24;
        val = longint'(d) & ((longint'(1) << w) - 1);
        if (val >= (longint'(1) << (w - 1))) val = val - (longint'(1) << w);
        return val * (longint'(1) << (24 - w));
    endfunction

    function automatic longint clampv(input longint x);
        if (x > LIM) return LIM;
        if (x < -LIM) return -LIM;
        return x;
    endfunction

    function automatic bit model_bit();
        return ((mmode ? m[4] : m[2]) >= 0);
    endfunction

    task automatic model_edge(input bit r, input bit e, input bit o,
                              input logic [1:0] f, input logic [DW-1:0] d);
        longint old [5];
        longint v, inp;
        if (r) begin
            for (int k = 0; k < 5; k++) m[k] = 0;
            mmode = 1'b0;
        end else if (o != mmode) begin
            for (int k = 0; k < 5; k++) m[k] = 0;
            mmode = o;
        end else if (e) begin
            v = model_bit() ? FS : -FS;
            for (int k = 0; k < 5; k++) old[k] = m[k];
            for (int k = 0; k < 5; k++) begin
                inp  = (k == 0) ? align(d, f) : old[k-1];
                m[k] = clampv(old[k] + ((inp - v) >>> sh[k]));
                if (!mmode && k >= 3) m[k] = 0;
            end
        end
    endtask

    task automatic step(input bit r, input bit e, input bit o,
                        input logic [1:0] f, input logic [DW-1:0] d, input string tag);
        bit exp_bit;
        rst = r; en = e; order5 = o; fmt = f; din = d;
        @(posedge clk);
        model_edge(r, e, o, f, d);
        @(negedge clk);
        exp_bit = model_bit();
        checks++;
        if (bit_out !== exp_bit) begin
            errors++;
            $display("FAIL %s: bit_out=%0b expected=%0b at %0t", tag, bit_out, exp_bit, $time);
        end
    endtask

    function automatic logic [DW-1:0] noisy(input longint val, input int w);
        logic [DW-1:0] r;
        r = DW'($urandom);
        return (r & ~DW'((longint'(1) << w) - 1)) | DW'(val & ((longint'(1) << w) - 1));
    endfunction

    initial begin
        longint s;
        @(negedge clk);
        // R1: reset state
        repeat (3) step(1, 0, 0, 3, '0, "R1 reset");
        // R3 R7: third order, zero input
        repeat (200) step(0, 1, 0, 3, '0, "R3 zero input");
        // R5: third order, ramping input
        for (int i = 0; i < 2000; i++) begin
            s = longint'((i % 400) - 200) * 20000;
            step(0, 1, 0, 3, DW'(s), "R5 ramp third order");
        end
        // R6: overload into the clamp, both polarities
        repeat (400) step(0, 1, 0, 3, 24'h7FFFFF, "R6 positive overload");
        repeat (400) step(0, 1, 0, 3, 24'h800000, "R6 negative overload");
        // R8: switch to fifth order, ignoring en
        step(0, 0, 1, 3, 24'h123456, "R8 order change");
        // R4: fifth order, random moderate input
        for (int i = 0; i < 2000; i++) begin
            s = longint'($signed(16'($urandom))) * 32;
            step(0, 1, 1, 3, DW'(s), "R4 fifth order");
        end
        repeat (300) step(0, 1, 1, 3, 24'h7FFFFF, "R6 fifth overload");
        // R8: back to third order mid-run
        step(0, 1, 0, 3, 24'h000100, "R8 back to third");
        // R2: narrow widths with garbage upper bits
        for (int f = 0; f < 3; f++) begin
            int w;
            w = (f == 0) ? 16 : (f == 1) ? 18 : 20;
            for (int i = 0; i < 500; i++) begin
                s = longint'($signed(12'($urandom))) * (longint'(1) << (w - 14));
                step(0, 1, 0, 2'(f), noisy(s, w), "R2 format");
            end
            step(0, 1, 1, 2'(f), '0, "R8 toggle order");
            for (int i = 0; i < 300; i++) begin
                s = longint'($signed(12'($urandom))) * (longint'(1) << (w - 14));
                step(0, 1, 1, 2'(f), noisy(s, w), "R2 format fifth");
            end
            step(0, 1, 0, 2'(f), '0, "R8 toggle order");
        end
        // R9: gaps in the enable
        for (int i = 0; i < 1500; i++) begin
            s = longint'($signed(14'($urandom))) * 256;
            step(0, 1'($urandom), 0, 3, DW'(s), "R9 enable gaps");
        end
        step(0, 0, 1, 3, '0, "R8 order change");
        for (int i = 0; i < 1000; i++) begin
            s = longint'($signed(14'($urandom))) * 256;
            step(0, 1'($urandom), 1, 3, DW'(s), "R9 enable gaps fifth");
        end
        // R1: reset mid-run in fifth order
        step(1, 1, 1, 3, 24'h400000, "R1 mid-run reset");
        step(0, 1, 0, 3, 24'h400000, "R1 third after reset");
        repeat (200) step(0, 1, 0, 3, 24'h200000, "R7 after reset");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule